// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This peripheral keeps a 32-bit count of elapsed seconds and compares it against a programmable alarm value. An external strobe marks each second; while counting is switched on, every strobe adds one to the count and raises a per-second event flag. When alarm matching is on and a strobe brings the count to the alarm value, an alarm event flag is raised as well. Each flag has its own interrupt enable, and a single interrupt line reports any enabled, pending flag.

Software reaches the block over a simple register bus with single-cycle reads and writes. A slow time-keeping domain is modelled by a small state machine with two states, `ST_READY` and `ST_SETTLE`. An accepted write moves it from `ST_READY` to `ST_SETTLE` (transition *accept*). It counts down there for a set number of cycles and then returns (transition *settle_done*). A write that arrives while the machine is in `ST_SETTLE` is dropped. The block also holds a general storage word that keeps its value, a regulator trim word, and a power-down request bit that drives an output pin.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset every register reads zero, the control word reads 0x80 (only the ready bit set), and `irq` and `pwr_down_req` are low.
- R2: Reads return control at offset 0x00, seconds at 0x04, alarm at 0x08, regulator trim at 0x0C, power-down at 0x20 and storage at 0x34. Any other offset reads zero. The control word has these bits: bit 7 ready (read-only), bit 6 second flag, bit 5 second interrupt enable, bit 4 alarm flag, bit 3 alarm interrupt enable, bit 2 alarm match enable, bit 0 count enable. Bit 1 and bits 31..8 read zero.
- R3: A write (`bus_sel` and `bus_we` high) issued while the ready bit is clear changes no register.
- R4: After an accepted write the ready bit is clear for BUSY_CYCLES cycles and then set again.
- R5: A `tick` strobe with count enable set increments seconds by one and sets the second flag. With count enable clear, the strobe changes nothing.
- R6: With alarm match enable and count enable set, a strobe whose incremented count equals the alarm value sets the alarm flag. With alarm match enable clear, the flag stays unchanged.
- R7: A control write with 0 in bit 6 or bit 4 clears that flag, and a 1 leaves it as it is. A flag set by a strobe in the same cycle as a clearing write stays set.
- R8: Seconds, alarm, regulator trim and storage take the written 32-bit value and hold it until the next accepted write.
- R9: `pwr_down_req` follows bit 0 of the last accepted write to the power-down offset.
- R10: `irq` is high exactly when (second flag and its enable) or (alarm flag and its enable) holds.
- R11: A seconds write in the same cycle as an enabled strobe loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| tick | input | 1 | One-cycle strobe, once per second |
| irq | output | 1 | Combined interrupt request |
| pwr_down_req | output | 1 | Power-down request |

## Verification
The embedded properties assume `tick` and the bus inputs are stable and known at each rising edge, and that reset is held for at least one edge before use. The bench changes inputs only on falling edges and keeps them set for a full cycle. It issues most writes only after its model shows the ready bit set. It also fires deliberate writes during `ST_SETTLE` and lines up strobes with same-cycle seconds and control writes, which reaches the priority cases of R7 and R11.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SEC   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ALARM = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIM  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_PDOWN = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_STORE = 6'h34;

    localparam int BIT_RDY   = 7;
    localparam int BIT_SECF  = 6;
    localparam int BIT_SECIE = 5;
    localparam int BIT_ALF   = 4;
    localparam int BIT_ALIE  = 3;
    localparam int BIT_ALEN  = 2;
    localparam int BIT_RUN   = 0;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_SETTLE = 1'b1
    } gate_state_t;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
    import rtc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    output logic wr_ready,
    output logic wr_acc
);
    localparam int CNT_W = $clog2(BUSY_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    gate_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                if (wr_req) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin
                    state_d = ST_READY;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wr_ready = (state_q == ST_READY);
        wr_acc   = wr_ready && wr_req;
    end

    // R4
    acc_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !wr_ready);

    // R4
    settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |-> (cnt_q <= CNT_LOAD));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ctrl_wr,
    input  logic              sec_wr,
    input  logic              alarm_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sec_q,
    output logic [DATA_W-1:0] alarm_q,
    output logic              run_q,
    output logic              alen_q,
    output logic              secie_q,
    output logic              alie_q,
    output logic              secf_q,
    output logic              alf_q
);
    logic              tick_go;
    logic [DATA_W-1:0] sec_inc;
    logic              hit;
    logic              secf_keep;
    logic              alf_keep;

    always_comb begin
        tick_go   = tick && run_q;
        sec_inc   = sec_q + 1'b1;
        hit       = tick_go && alen_q && (sec_inc == alarm_q);
        secf_keep = !(ctrl_wr && !wdata[BIT_SECF]);
        alf_keep  = !(ctrl_wr && !wdata[BIT_ALF]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            alarm_q <= '0;
            run_q   <= 1'b0;
            alen_q  <= 1'b0;
            secie_q <= 1'b0;
            alie_q  <= 1'b0;
            secf_q  <= 1'b0;
            alf_q   <= 1'b0;
        end else begin
            if (sec_wr)       sec_q <= wdata;
            else if (tick_go) sec_q <= sec_inc;
            if (alarm_wr) alarm_q <= wdata;
            if (ctrl_wr) begin
                run_q   <= wdata[BIT_RUN];
                alen_q  <= wdata[BIT_ALEN];
                secie_q <= wdata[BIT_SECIE];
                alie_q  <= wdata[BIT_ALIE];
            end
            secf_q <= tick_go || (secf_q && secf_keep);
            alf_q  <= hit || (alf_q && alf_keep);
        end
    end

    // R5
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_q && !sec_wr) |=> (sec_q == $past(sec_q) + 1'b1));

    // R5
    secf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(secf_q) |-> $past(tick));

    // R6
    alf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alf_q) |-> ($past(tick) && $past(alen_q)));

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        sec_wr |=> (sec_q == $past(wdata)));
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              irq,
    output logic              pwr_down_req
);
    logic wr_req, wr_ready, wr_acc;
    logic ctrl_wr, sec_wr, alarm_wr, trim_wr, pdown_wr, store_wr;
    logic [DATA_W-1:0] sec_q, alarm_q, trim_q, store_q;
    logic run_q, alen_q, secie_q, alie_q, secf_q, alf_q, pdown_q;
    logic [7:0] ctrl_rd;

    assign wr_req = bus_sel && bus_we;

    rtc_wr_gate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .wr_ready (wr_ready),
        .wr_acc   (wr_acc)
    );

    always_comb begin
        ctrl_wr  = wr_acc && (bus_addr == OFS_CTRL);
        sec_wr   = wr_acc && (bus_addr == OFS_SEC);
        alarm_wr = wr_acc && (bus_addr == OFS_ALARM);
        trim_wr  = wr_acc && (bus_addr == OFS_TRIM);
        pdown_wr = wr_acc && (bus_addr == OFS_PDOWN);
        store_wr = wr_acc && (bus_addr == OFS_STORE);
    end

    rtc_time_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ctrl_wr  (ctrl_wr),
        .sec_wr   (sec_wr),
        .alarm_wr (alarm_wr),
        .wdata    (bus_wdata),
        .sec_q    (sec_q),
        .alarm_q  (alarm_q),
        .run_q    (run_q),
        .alen_q   (alen_q),
        .secie_q  (secie_q),
        .alie_q   (alie_q),
        .secf_q   (secf_q),
        .alf_q    (alf_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q  <= '0;
            store_q <= '0;
            pdown_q <= 1'b0;
        end else begin
            if (trim_wr)  trim_q  <= bus_wdata;
            if (store_wr) store_q <= bus_wdata;
            if (pdown_wr) pdown_q <= bus_wdata[0];
        end
    end

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[BIT_RDY]   = wr_ready;
        ctrl_rd[BIT_SECF]  = secf_q;
        ctrl_rd[BIT_SECIE] = secie_q;
        ctrl_rd[BIT_ALF]   = alf_q;
        ctrl_rd[BIT_ALIE]  = alie_q;
        ctrl_rd[BIT_ALEN]  = alen_q;
        ctrl_rd[BIT_RUN]   = run_q;
        case (bus_addr)
            OFS_CTRL:  bus_rdata = {{(DATA_W-8){1'b0}}, ctrl_rd};
            OFS_SEC:   bus_rdata = sec_q;
            OFS_ALARM: bus_rdata = alarm_q;
            OFS_TRIM:  bus_rdata = trim_q;
            OFS_PDOWN: bus_rdata = {{(DATA_W-1){1'b0}}, pdown_q};
            OFS_STORE: bus_rdata = store_q;
            default:   bus_rdata = '0;
        endcase
        irq          = (secf_q && secie_q) || (alf_q && alie_q);
        pwr_down_req = pdown_q;
    end

    // R3
    busy_store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ready) |=> ($stable(store_q) && $stable(trim_q) && $stable(pdown_q)));

    // R9
    pdown_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down_req) |-> $past(pdown_wr && bus_wdata[0]));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!secie_q && !alie_q) |-> !irq);
endmodule

// File: tb/tb_rtc_sec_alarm.sv
module tb_rtc_sec_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0, tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, pwr_down_req;

    int n_chk = 0;
    int n_fail = 0;

    rtc_sec_alarm #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .irq(irq), .pwr_down_req(pwr_down_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [31:0] m_sec, m_alarm, m_trim, m_store;
    bit m_pd, m_run, m_alen, m_secie, m_alie, m_secf, m_alf, m_ready;
    int m_wait;

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_alarm = 0; m_trim = 0; m_store = 0;
            m_pd = 0; m_run = 0; m_alen = 0; m_secie = 0; m_alie = 0;
            m_secf = 0; m_alf = 0; m_ready = 1; m_wait = 0;
        end else begin
            bit take, fire, match;
            logic [31:0] nxt;
            take  = bus_sel && bus_we && m_ready;
            fire  = tick && m_run;
            nxt   = m_sec + 1;
            match = fire && m_alen && (nxt == m_alarm);
            if (take && bus_addr == 6'h00) begin
                if (!bus_wdata[6]) m_secf = 0;
                if (!bus_wdata[4]) m_alf = 0;
            end
            if (fire) m_secf = 1;
            if (match) m_alf = 1;
            if (take && bus_addr == 6'h00) begin
                m_run = bus_wdata[0]; m_alen = bus_wdata[2];
                m_secie = bus_wdata[5]; m_alie = bus_wdata[3];
            end
            if (take && bus_addr == 6'h04) m_sec = bus_wdata;
            else if (fire) m_sec = nxt;
            if (take && bus_addr == 6'h08) m_alarm = bus_wdata;
            if (take && bus_addr == 6'h0C) m_trim = bus_wdata;
            if (take && bus_addr == 6'h34) m_store = bus_wdata;
            if (take && bus_addr == 6'h20) m_pd = bus_wdata[0];
            if (take) begin
                m_ready = 0; m_wait = BUSY - 1;
            end else if (!m_ready) begin
                if (m_wait == 0) m_ready = 1;
                else m_wait = m_wait - 1;
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [5:0] a);
        case (a)
            6'h00: return {24'd0, m_ready, m_secf, m_secie, m_alf, m_alie, m_alen, 1'b0, m_run};
            6'h04: return m_sec;
            6'h08: return m_alarm;
            6'h0C: return m_trim;
            6'h20: return {31'd0, m_pd};
            6'h34: return m_store;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [5:0] a,
                        input logic [31:0] d, input logic t);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; tick = t;
        @(posedge clk);
        @(negedge clk);
        chk("R2 read vs model", bus_rdata, model_rd(bus_addr));
        chk("R10 irq vs model", {31'd0, irq}, {31'd0, (m_secf && m_secie) || (m_alf && m_alie)});
        chk("R9 pwr_down_req vs model", {31'd0, pwr_down_req}, {31'd0, m_pd});
    endtask

    task automatic idle_until_ready();
        for (int i = 0; i < 20 && !m_ready; i++) step(1'b0, 1'b0, 6'h00, 32'd0, 1'b0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        idle_until_ready();
        step(1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
        step(1'b1, 1'b0, a, 32'd0, 1'b0);
        chk(tag, bus_rdata, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_exp(6'h00, 32'h80, "R1 ctrl after reset");
        rd_exp(6'h04, 32'h0, "R1 seconds after reset");
        rd_exp(6'h34, 32'h0, "R1 storage after reset");
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 pwr_down_req after reset", {31'd0, pwr_down_req}, 32'd0);
        // R8 storage and trim
        wr(6'h34, 32'hA5A5_5A5A);
        // R4 ready low window
        for (int i = 1; i < BUSY; i++) rd_exp(6'h00, 32'h00, "R4 ready low after write");
        rd_exp(6'h00, 32'h80, "R4 ready back high");
        rd_exp(6'h34, 32'hA5A5_5A5A, "R8 storage written");
        // R3 write during settle ignored
        wr(6'h0C, 32'h0000_1234);
        step(1'b1, 1'b1, 6'h34, 32'h1111_2222, 1'b0);
        step(1'b1, 1'b1, 6'h0C, 32'hFFFF_FFFF, 1'b0);
        idle_until_ready();
        rd_exp(6'h34, 32'hA5A5_5A5A, "R3 storage unchanged by busy write");
        rd_exp(6'h0C, 32'h0000_1234, "R3 trim unchanged by busy write");
        // R2 unmapped offset
        rd_exp(6'h10, 32'h0, "R2 unmapped offset reads zero");
        // R5 tick with count disabled
        step(1'b0, 1'b0, 6'h00, 32'd0, 1'b1);
        rd_exp(6'h04, 32'h0, "R5 no count while disabled");
        // setup: seconds 0x10, alarm 0x12, run+alen+secie+alie = 0x2D
        wr(6'h04, 32'h10);
        wr(6'h08, 32'h12);
        wr(6'h00, 32'h2D);
        idle_until_ready();
        step(1'b0, 1'b0, 6'h04, 32'd0, 1'b1);
        rd_exp(6'h04, 32'h11, "R5 count advanced by tick");
        step(1'b0, 1'b0, 6'h04, 32'd0, 1'b1);
        rd_exp(6'h00, 32'hFD, "R6 alarm flag set at match");
        chk("R10 irq with flags enabled", {31'd0, irq}, 32'd1);
        // R7 write 1 keeps second flag, 0 clears alarm flag
        wr(6'h00, 32'h6D);
        idle_until_ready();
        rd_exp(6'h00, 32'hED, "R7 flag clear by zero, kept by one");
        // R10 disable second interrupt: irq drops
        wr(6'h00, 32'h4D);
        idle_until_ready();
        chk("R10 irq off when enable cleared", {31'd0, irq}, 32'd0);
        // R7 clearing write coincides with tick: set wins
        step(1'b1, 1'b1, 6'h00, 32'h0D, 1'b1);
        idle_until_ready();
        rd_exp(6'h00, 32'hCD, "R7 tick set beats same-cycle clear");
        // R6 alarm enable off: no flag on match
        wr(6'h00, 32'h09);
        wr(6'h08, 32'h14);
        idle_until_ready();
        step(1'b0, 1'b0, 6'h00, 32'd0, 1'b1);
        rd_exp(6'h00, 32'hC9, "R6 no alarm flag without match enable");
        // R11 seconds write beats tick
        idle_until_ready();
        step(1'b1, 1'b1, 6'h04, 32'h100, 1'b1);
        rd_exp(6'h04, 32'h100, "R11 load wins over tick");
        // R9 power-down request
        wr(6'h20, 32'h1);
        chk("R9 request raised", {31'd0, pwr_down_req}, 32'd1);
        wr(6'h20, 32'h0);
        chk("R9 request dropped", {31'd0, pwr_down_req}, 32'd0);
        // mixed traffic compared to the model every cycle
        for (int i = 0; i < 300; i++) begin
            logic [5:0] a;
            case (i % 7)
                0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C;
                4: a = 6'h20; 5: a = 6'h34; default: a = 6'h18;
            endcase
            step((i % 3) != 0, (i % 5) == 1, a,
                 (a == 6'h00) ? (32'h3D ^ 32'(i & 32'h50)) : 32'(i * 7 + 13),
                 (i % 4) == 2);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule